// File: doc/BRIEF.md
# Banked Interrupt Distributor Control Register

This block is the top-level control word of an interrupt distributor. It stores the group enables (group 0, non-secure group 1, secure group 1), one routing-mode enable per security state, a security-disable flag, a wakeup-selection option and, in the single-state view, a control that removes the active state of software-generated interrupts. A single register port carries a secure-access flag. The same 32-bit word therefore reads and writes differently for a secure caller, a non-secure caller, and any caller once security has been disabled.

The decoded enables and routing modes go straight to the rest of the distributor. A busy flag stays high while a change to a propagated field settles, for a parameterised number of cycles. A one-cycle pulse per group marks every enable that falls from 1 to 0, so that downstream logic can pull back interrupts that were already forwarded. A write is always decoded with the layout that was in force before it, even when the write changes the routing mode or the security-disable bit.

Top module: `irq_dist_ctrl`

## Requirements
- R1: After reset every enable, routing, security-disable, wakeup and SGI output is 0, write_pend is 0, no pulse is raised, and both the secure and non-secure reads return 0.
- R2: With security enabled, a secure read returns bit 0 group-0 enable, bit 1 non-secure group-1 enable, bit 2 secure group-1 enable, bit 4 secure routing, bit 5 non-secure routing, bit 6 security-disable, bit 7 wakeup option and bit 31 busy. All other bits read 0, and secure writes set the writable fields at those positions.
- R3: With security enabled, a non-secure read shows busy at bit 31 and non-secure routing at bit 4. The non-secure group-1 enable appears at bit 1 when non-secure routing is 1 and at bit 0 when it is 0. The unused bit of the two reads 0 and a write to it has no effect. Non-secure writes never change the group-0 enable.
- R4: While secure routing is 1, non-secure routing reads as 1 in both views and writes to it have no effect.
- R5: The secure group-1 enable reads 0 and ignores writes while secure routing is 0. It is forced to 0 when secure routing is cleared or security is disabled.
- R6: Once security-disable is 1 it stays 1 until reset. While it is 1, every access uses the single-state layout: bit 0 group 0, bit 1 group 1, bit 4 routing, bit 6 reads 1, bit 7 wakeup, bit 8 SGI no-active-state, bit 31 busy.
- R7: A write that changes a routing bit or security-disable is decoded with the layout in force before the write. For example, a non-secure write of 0x13 with non-secure routing 0 takes the group-1 enable from bit 0.
- R8: A write that changes any of group 0, group 1, secure group 1, either routing bit or security-disable holds write_pend (and read bit 31) at 1 for exactly PROP_CYCLES cycles, restarting on each such change. A write that changes none of them does not raise it.
- R9: In the single-state view, bit 8 ignores writes while group 0 or group 1 is enabled before the write.
- R10: For each group, off_pulse (bit 0 group 0, bit 1 non-secure group 1, bit 2 secure group 1) is 1 for exactly the one cycle in which that enable has just fallen from 1 to 0.
- R11: The wakeup option is read and written at bit 7 in the secure and single-state views, reads 0 in the non-secure view, and does not start the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_secure | input | 1 | Access is secure (selects view for read and write) |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data in the current view (combinational) |
| grp0_en | output | 1 | Group 0 enabled |
| grp1ns_en | output | 1 | Non-secure (or single) group 1 enabled |
| grp1s_en | output | 1 | Secure group 1 enabled |
| route_s_en | output | 1 | Secure (or single) routing mode enabled |
| route_ns_en | output | 1 | Non-secure routing mode in effect |
| sec_disable | output | 1 | Security disabled |
| wake_pick_en | output | 1 | Sleeping cores may be picked |
| sgi_no_active | output | 1 | SGIs have no active state |
| write_pend | output | 1 | A tracked change is still propagating |
| off_pulse | output | 3 | Per-group enable fall pulse |

## Verification
The hardest situations to reach are writes that change the layout they themselves are decoded with: a non-secure write that turns on non-secure routing while carrying the group-1 enable, and a secure write that turns on security-disable together with enables. Both can only be reached through ordered write sequences. The stimulus walks every combination of the meaningful write bits in both views from whatever state the previous write left, so routing bits toggle under live enables. A separate sweep after security-disable covers the single-state view and its SGI write lock. Every write is followed by reads in both views, compared with an arithmetic model of the requirements.

// File: rtl/irq_dist_ctrl_pkg.sv
package irq_dist_ctrl_pkg;

   localparam int unsigned BIT_G0    = 0;
   localparam int unsigned BIT_G1    = 1;
   localparam int unsigned BIT_G1S   = 2;
   localparam int unsigned BIT_RS    = 4;
   localparam int unsigned BIT_RNS   = 5;
   localparam int unsigned BIT_NS_RT = 4;
   localparam int unsigned BIT_DS    = 6;
   localparam int unsigned BIT_WAKE  = 7;
   localparam int unsigned BIT_SGI   = 8;
   localparam int unsigned BIT_BUSY  = 31;

   localparam int unsigned NUM_GRP   = 3;

   typedef struct packed {
      logic sgi_na;
      logic wake;
      logic ds;
      logic are_ns;
      logic are_s;
      logic g1s;
      logic g1ns;
      logic g0;
   } ctrl_fields_t;

   // fields whose change starts the propagation window
   localparam logic [7:0] TRACK_MASK = 8'h3F;

   typedef enum logic [1:0] {
      VIEW_SEC    = 2'd0,
      VIEW_NSEC   = 2'd1,
      VIEW_SINGLE = 2'd2
   } view_e;

   function automatic view_e pick_view(input logic ds, input logic secure);
      if (ds)
         return VIEW_SINGLE;
      else if (secure)
         return VIEW_SEC;
      else
         return VIEW_NSEC;
   endfunction

endpackage

// File: rtl/ctrl_wr_decode.sv
module ctrl_wr_decode
   import irq_dist_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter bit          HAS_WAKE    = 1'b1,
   parameter bit          HAS_SGI_ACT = 1'b1,
   parameter bit          DS_PROG     = 1'b1
) (
   input  ctrl_fields_t      cur,
   input  logic              acc_secure,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wd,
   output ctrl_fields_t      nxt,
   output logic              tracked_chg
);

   logic  wake_bit;
   logic  sgi_bit;
   logic  ds_bit;
   logic  eff_rns;
   view_e view;
   logic  unused_wd;

   assign unused_wd = ^wd;

   generate
      if (HAS_WAKE) begin : g_wake
         assign wake_bit = wd[BIT_WAKE];
      end else begin : g_no_wake
         assign wake_bit = 1'b0;
      end
      if (HAS_SGI_ACT) begin : g_sgi
         assign sgi_bit = wd[BIT_SGI];
      end else begin : g_no_sgi
         assign sgi_bit = 1'b0;
      end
      if (DS_PROG) begin : g_ds
         assign ds_bit = wd[BIT_DS];
      end else begin : g_no_ds
         assign ds_bit = 1'b0;
      end
   endgenerate

   assign view    = pick_view(cur.ds, acc_secure);
   assign eff_rns = cur.are_s | cur.are_ns;

   always_comb begin
      nxt = cur;
      if (wr_en) begin
         unique case (view)
            VIEW_SINGLE: begin
               nxt.g0    = wd[BIT_G0];
               nxt.g1ns  = wd[BIT_G1];
               nxt.are_s = wd[BIT_RS];
               nxt.wake  = wake_bit;
               if (!(cur.g0 || cur.g1ns))
                  nxt.sgi_na = sgi_bit;
            end
            VIEW_SEC: begin
               nxt.g0    = wd[BIT_G0];
               nxt.g1ns  = wd[BIT_G1];
               if (cur.are_s)
                  nxt.g1s = wd[BIT_G1S];
               nxt.are_s = wd[BIT_RS];
               if (!cur.are_s)
                  nxt.are_ns = wd[BIT_RNS];
               nxt.ds    = ds_bit;
               nxt.wake  = wake_bit;
            end
            VIEW_NSEC: begin
               // alias position chosen by the layout before this write
               nxt.g1ns = eff_rns ? wd[BIT_G1] : wd[BIT_G0];
               if (!cur.are_s)
                  nxt.are_ns = wd[BIT_NS_RT];
            end
            default: ;
         endcase
      end
      if (!nxt.are_s || nxt.ds)
         nxt.g1s = 1'b0;
   end

   assign tracked_chg = |((nxt ^ cur) & TRACK_MASK);

endmodule

// File: rtl/ctrl_rd_view.sv
module ctrl_rd_view
   import irq_dist_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  ctrl_fields_t      cur,
   input  logic              acc_secure,
   input  logic              busy,
   output logic [DATA_W-1:0] rd_data
);

   view_e view;
   logic  eff_rns;

   assign view    = pick_view(cur.ds, acc_secure);
   assign eff_rns = cur.are_s | cur.are_ns;

   always_comb begin
      rd_data           = '0;
      rd_data[BIT_BUSY] = busy;
      unique case (view)
         VIEW_SINGLE: begin
            rd_data[BIT_G0]   = cur.g0;
            rd_data[BIT_G1]   = cur.g1ns;
            rd_data[BIT_RS]   = cur.are_s;
            rd_data[BIT_DS]   = 1'b1;
            rd_data[BIT_WAKE] = cur.wake;
            rd_data[BIT_SGI]  = cur.sgi_na;
         end
         VIEW_SEC: begin
            rd_data[BIT_G0]   = cur.g0;
            rd_data[BIT_G1]   = cur.g1ns;
            rd_data[BIT_G1S]  = cur.g1s;
            rd_data[BIT_RS]   = cur.are_s;
            rd_data[BIT_RNS]  = eff_rns;
            rd_data[BIT_DS]   = cur.ds;
            rd_data[BIT_WAKE] = cur.wake;
         end
         VIEW_NSEC: begin
            rd_data[BIT_NS_RT] = eff_rns;
            rd_data[BIT_G1]    = eff_rns & cur.g1ns;
            rd_data[BIT_G0]    = ~eff_rns & cur.g1ns;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/ctrl_pend_timer.sv
module ctrl_pend_timer #(
   parameter int unsigned PROP_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic busy
);

   localparam int unsigned CNT_W = $clog2(PROP_CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= CNT_W'(PROP_CYCLES);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/ctrl_fall_pulse.sv
module ctrl_fall_pulse #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] now_val,
   input  logic [N-1:0] next_val,
   output logic [N-1:0] pulse
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               pulse[i] <= 1'b0;
            else
               pulse[i] <= now_val[i] & ~next_val[i];
         end
      end
   endgenerate

endmodule

// File: rtl/irq_dist_ctrl.sv
module irq_dist_ctrl
   import irq_dist_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned PROP_CYCLES = 4,
   parameter bit          HAS_WAKE    = 1'b1,
   parameter bit          HAS_SGI_ACT = 1'b1,
   parameter bit          DS_PROG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_secure,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              grp0_en,
   output logic              grp1ns_en,
   output logic              grp1s_en,
   output logic              route_s_en,
   output logic              route_ns_en,
   output logic              sec_disable,
   output logic              wake_pick_en,
   output logic              sgi_no_active,
   output logic              write_pend,
   output logic [2:0]        off_pulse
);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("irq_dist_ctrl: DATA_W must be 32");
      end
      if (PROP_CYCLES < 1) begin : g_bad_prop
         $error("irq_dist_ctrl: PROP_CYCLES must be at least 1");
      end
   endgenerate

   ctrl_fields_t cur;
   ctrl_fields_t nxt;
   logic         tracked_chg;

   ctrl_wr_decode #(
      .DATA_W      (DATA_W),
      .HAS_WAKE    (HAS_WAKE),
      .HAS_SGI_ACT (HAS_SGI_ACT),
      .DS_PROG     (DS_PROG)
   ) i_dec (
      .cur         (cur),
      .acc_secure  (acc_secure),
      .wr_en       (wr_en),
      .wd          (wr_data),
      .nxt         (nxt),
      .tracked_chg (tracked_chg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         cur <= '0;
      else
         cur <= nxt;
   end

   ctrl_pend_timer #(
      .PROP_CYCLES (PROP_CYCLES)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (tracked_chg),
      .busy    (write_pend)
   );

   ctrl_rd_view #(
      .DATA_W (DATA_W)
   ) i_view (
      .cur        (cur),
      .acc_secure (acc_secure),
      .busy       (write_pend),
      .rd_data    (rd_data)
   );

   ctrl_fall_pulse #(
      .N (NUM_GRP)
   ) i_fall (
      .clk      (clk),
      .rst_n    (rst_n),
      .now_val  ({cur.g1s, cur.g1ns, cur.g0}),
      .next_val ({nxt.g1s, nxt.g1ns, nxt.g0}),
      .pulse    (off_pulse)
   );

   assign grp0_en       = cur.g0;
   assign grp1ns_en     = cur.g1ns;
   assign grp1s_en      = cur.g1s;
   assign route_s_en    = cur.are_s;
   assign route_ns_en   = cur.ds ? cur.are_s : (cur.are_s | cur.are_ns);
   assign sec_disable   = cur.ds;
   assign wake_pick_en  = cur.wake;
   assign sgi_no_active = cur.sgi_na;

endmodule

// File: rtl/irq_dist_ctrl_chk.sv
module irq_dist_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_secure,
   input logic [31:0] rd_data,
   input logic        grp0_en,
   input logic        grp1ns_en,
   input logic        grp1s_en,
   input logic        route_s_en,
   input logic        route_ns_en,
   input logic        sec_disable,
   input logic        write_pend,
   input logic [2:0]  off_pulse
);

   a_r10_g0_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      off_pulse[0] |-> ($past(grp0_en) && !grp0_en));
   a_r10_g1ns_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      off_pulse[1] |-> ($past(grp1ns_en) && !grp1ns_en));
   a_r10_g1s_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      off_pulse[2] |-> ($past(grp1s_en) && !grp1s_en));
   a_r10_fall_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp0_en && $past(grp0_en)) |-> off_pulse[0]);

   a_r6_ds_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sec_disable) |-> sec_disable);
   a_r6_ds_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
      sec_disable |-> rd_data[6]);

   a_r5_g1s_gated: assert property (@(posedge clk) disable iff (!rst_n)
      grp1s_en |-> (route_s_en && !sec_disable));

   a_r4_ns_route_forced: assert property (@(posedge clk) disable iff (!rst_n)
      route_s_en |-> route_ns_en);

   a_r8_change_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (grp0_en != $past(grp0_en)) |-> write_pend);
   a_r8_pend_visible: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[31] == write_pend);

   a_r3_ns_single_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_secure && !sec_disable) |-> !(rd_data[0] && rd_data[1]));

endmodule

bind irq_dist_ctrl irq_dist_ctrl_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_secure  (acc_secure),
   .rd_data     (rd_data),
   .grp0_en     (grp0_en),
   .grp1ns_en   (grp1ns_en),
   .grp1s_en    (grp1s_en),
   .route_s_en  (route_s_en),
   .route_ns_en (route_ns_en),
   .sec_disable (sec_disable),
   .write_pend  (write_pend),
   .off_pulse   (off_pulse)
);

// File: tb/test_irq_dist_ctrl.sv
`timescale 1ns/1ps
module test_irq_dist_ctrl;

   localparam int P = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_secure = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        grp0_en, grp1ns_en, grp1s_en, route_s_en, route_ns_en;
   logic        sec_disable, wake_pick_en, sgi_no_active, write_pend;
   logic [2:0]  off_pulse;

   always #2.5 clk = ~clk;

   irq_dist_ctrl #(.PROP_CYCLES(P)) i_irq_dist_ctrl (
      .clk(clk), .rst_n(rst_n), .acc_secure(acc_secure), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .grp0_en(grp0_en),
      .grp1ns_en(grp1ns_en), .grp1s_en(grp1s_en), .route_s_en(route_s_en),
      .route_ns_en(route_ns_en), .sec_disable(sec_disable),
      .wake_pick_en(wake_pick_en), .sgi_no_active(sgi_no_active),
      .write_pend(write_pend), .off_pulse(off_pulse)
   );

   int checks = 0;
   int errors = 0;

   // model of the requirements
   bit m_g0, m_g1, m_g1s, m_rs, m_rns, m_ds, m_wk, m_sg;
   bit o_g0, o_g1, o_g1s, o_rs, o_rns, o_ds;
   bit [2:0] m_pl;
   int m_cnt;

   task automatic mdl_write(input bit sec, input logic [31:0] d);
      bit eff;
      eff = m_rs | m_rns;
      if (m_ds) begin
         if (!(m_g0 || m_g1)) m_sg = d[8];
         m_g0 = d[0]; m_g1 = d[1]; m_rs = d[4]; m_wk = d[7];
      end else if (sec) begin
         if (m_rs) m_g1s = d[2];
         if (!m_rs) m_rns = d[5];
         m_g0 = d[0]; m_g1 = d[1]; m_rs = d[4]; m_ds = d[6]; m_wk = d[7];
      end else begin
         m_g1 = eff ? d[1] : d[0];
         if (!m_rs) m_rns = d[4];
      end
      if (!m_rs || m_ds) m_g1s = 1'b0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_g0, m_g1, m_g1s, m_rs, m_rns, m_ds, m_wk, m_sg} = '0;
         m_pl = '0; m_cnt = 0;
      end else begin
         {o_g0, o_g1, o_g1s, o_rs, o_rns, o_ds} = {m_g0, m_g1, m_g1s, m_rs, m_rns, m_ds};
         if (wr_en) mdl_write(acc_secure, wr_data);
         m_pl = {o_g1s & ~m_g1s, o_g1 & ~m_g1, o_g0 & ~m_g0};
         if ({o_g0, o_g1, o_g1s, o_rs, o_rns, o_ds} != {m_g0, m_g1, m_g1s, m_rs, m_rns, m_ds})
            m_cnt = P;
         else if (m_cnt > 0)
            m_cnt = m_cnt - 1;
      end
   end

   function automatic logic [31:0] exp_rd(input bit sec);
      logic [31:0] r;
      bit eff;
      eff = m_rs | m_rns;
      r = '0;
      r[31] = (m_cnt != 0);
      if (m_ds) begin
         r[8] = m_sg; r[7] = m_wk; r[6] = 1'b1; r[4] = m_rs; r[1] = m_g1; r[0] = m_g0;
      end else if (sec) begin
         r[7] = m_wk; r[5] = eff; r[4] = m_rs; r[2] = m_g1s; r[1] = m_g1; r[0] = m_g0;
      end else begin
         r[4] = eff; r[1] = eff & m_g1; r[0] = ~eff & m_g1;
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge, with wr_en low
   task automatic compare_all(input string tag);
      logic [31:0] ea, ee;
      ea = {19'd0, grp0_en, grp1ns_en, grp1s_en, route_s_en, route_ns_en,
            sec_disable, wake_pick_en, sgi_no_active, write_pend, off_pulse};
      ee = {19'd0, m_g0, m_g1, m_g1s, m_rs, (m_ds ? m_rs : (m_rs | m_rns)),
            m_ds, m_wk, m_sg, (m_cnt != 0), m_pl};
      chk({tag, " outputs"}, ea, ee);
      acc_secure = 1'b1; #0.2;
      chk({tag, " secure read"}, rd_data, exp_rd(1'b1));
      acc_secure = 1'b0; #0.2;
      chk({tag, " nonsecure read"}, rd_data, exp_rd(1'b0));
   endtask

   task automatic wr(input bit sec, input logic [31:0] d);
      @(negedge clk);
      acc_secure = sec; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   bit done = 1'b0;

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      do_reset();
      compare_all("R1 reset");
      chk("R1 reset secure read", rd_data, 32'h0);

      // sweep of meaningful bits in both views, security enabled
      for (int i = 0; i < 128; i++) begin
         logic [31:0] d;
         d = 32'h0000_1008;
         d[0] = i[1]; d[1] = i[2]; d[2] = i[3]; d[4] = i[4]; d[5] = i[5]; d[7] = i[6];
         wr(i[0], d);
         compare_all("R2 R3 R4 R5 R7 R10 sweep");
      end

      // R7: layout before the write decides the alias position
      do_reset();
      wr(1'b0, 32'h13);
      chk("R7 ns routing set", {31'd0, route_ns_en}, 32'd1);
      chk("R7 grp1 from bit0", {31'd0, grp1ns_en}, 32'd1);
      wr(1'b0, 32'h01);
      chk("R7 grp1 from bit1 while routing cleared", {31'd0, grp1ns_en}, 32'd0);
      wr(1'b0, 32'h02);
      chk("R3 unused alias bit ignored", {31'd0, grp1ns_en}, 32'd0);
      compare_all("R3 R7 directed");

      // R3: non-secure cannot touch group 0
      do_reset();
      wr(1'b1, 32'h01);
      wr(1'b0, 32'h00);
      chk("R3 ns write leaves group0", {31'd0, grp0_en}, 32'd1);

      // R4
      wr(1'b1, 32'h11);
      wr(1'b0, 32'h00);
      chk("R4 ns routing forced", {31'd0, route_ns_en}, 32'd1);
      compare_all("R4 directed");

      // R5 and R10
      do_reset();
      wr(1'b1, 32'h04);
      chk("R5 g1s ignored without routing", {31'd0, grp1s_en}, 32'd0);
      wr(1'b1, 32'h14);
      chk("R5 g1s old layout", {31'd0, grp1s_en}, 32'd0);
      wr(1'b1, 32'h14);
      chk("R5 g1s set", {31'd0, grp1s_en}, 32'd1);
      wr(1'b1, 32'h04);
      chk("R5 g1s cleared with routing", {31'd0, grp1s_en}, 32'd0);
      chk("R10 g1s pulse", {29'd0, off_pulse}, 32'd4);
      @(negedge clk);
      chk("R10 pulse one cycle", {29'd0, off_pulse}, 32'd0);

      // R8 and R11
      do_reset();
      wr(1'b1, 32'h01);
      n = 0;
      while (write_pend && n < 100) begin
         n++;
         @(negedge clk);
      end
      chk("R8 busy length", n, P);
      wr(1'b1, 32'h01);
      chk("R8 no change no busy", {31'd0, write_pend}, 32'd0);
      wr(1'b1, 32'h81);
      chk("R11 wake set", {31'd0, wake_pick_en}, 32'd1);
      chk("R11 wake not tracked", {31'd0, write_pend}, 32'd0);
      compare_all("R11 directed");

      // R6 and R9
      do_reset();
      wr(1'b1, 32'h43);
      chk("R6 ds set", {31'd0, sec_disable}, 32'd1);
      wr(1'b1, 32'h103);
      chk("R9 sgi locked by enables", {31'd0, sgi_no_active}, 32'd0);
      wr(1'b0, 32'h00);
      chk("R6 ds sticky, single view group0", {30'd0, sec_disable, grp0_en}, 32'd2);
      wr(1'b0, 32'h100);
      chk("R9 sgi written with enables off", {31'd0, sgi_no_active}, 32'd1);
      compare_all("R6 R9 directed");
      for (int i = 0; i < 128; i++) begin
         logic [31:0] d;
         d = 32'h0000_0028;
         d[0] = i[1]; d[1] = i[2]; d[4] = i[3]; d[7] = i[4]; d[8] = i[5]; d[2] = i[6];
         wr(i[0], d);
         compare_all("R6 R9 R11 single sweep");
      end
      do_reset();
      chk("R6 reset clears ds", {31'd0, sec_disable}, 32'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule